// File: doc/BRIEF.md
# Pipelined Four-Digit Decimal Multiplier

This block multiplies two unsigned decimal operands, each four BCD digits wide, and returns the eight-digit BCD product. Each pair of digits is multiplied as a plain 4-bit by 4-bit binary product, so no digit needs recoding. These binary products are then collected into two-digit columns. One set of columns starts on even decimal positions and the other on odd positions, so the two sets are offset by one digit. Each column is summed in binary, and every column total is converted to decimal by shift-and-add-3. The converted columns leave exactly three decimal operands, and two levels of ripple-carry BCD adders combine them into the product.

The datapath is a four-stage pipeline that never stalls. A new operand pair can be presented on every clock by raising `in_valid`. The product appears on `prod` with `out_valid` high four clocks later. There is no ready signal and no back-pressure: the consumer must take every result in the cycle it is offered. `prod` is meaningful only while `out_valid` is high. The digit count is the parameter `N_DIG`. The column scheme assumes no column holds more than twelve digit products, which is the case for any `N_DIG` up to 12.

Top module: `bcdm_mul4`

## Requirements
- R1: When `in_valid` is high and every nibble of `opa` and `opb` is a BCD digit (0 to 9, least significant digit in bits 3:0), the matching `prod` equals the decimal product of the two operands, written as eight BCD digits with the least significant digit in bits 3:0.
- R2: The result for an operand pair sampled at a rising edge is presented after the fourth rising edge, counting the sampling edge as the first, and not earlier.
- R3: `out_valid` equals `in_valid` delayed by four clocks. A pair accepted on every consecutive clock produces a result on every consecutive clock, in the same order.
- R4: A synchronous, active-high `rst` clears every valid flag in the pipeline. `out_valid` is low in the cycle after reset is sampled and stays low until a pair accepted after reset has had four clocks to pass through.
- R5: Every nibble of `prod` is a legal BCD digit (0 to 9) while `out_valid` is high, and so is every nibble of each intermediate decimal operand.
- R6: The largest operands, 9999 × 9999, give 99980001.
- R7: An operand of zero on either side gives a product of zero.
- R8: Neither level of decimal addition carries out of the top product digit.
- R9: Each binary column total never exceeds 81 times the number of digit products in that column. The column at the top position never produces a hundreds digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Marks `opa`/`opb` as a pair to multiply this cycle |
| opa | input | 4*N_DIG (16) | Multiplicand, BCD digits, least significant in bits 3:0 |
| opb | input | 4*N_DIG (16) | Multiplier, BCD digits, least significant in bits 3:0 |
| out_valid | output | 1 | Marks `prod` as a result |
| prod | output | 8*N_DIG (32) | Product, BCD digits, least significant in bits 3:0 |

## Verification
Every product is due exactly four rising edges after the edge that samples its operands. No result has a different latency. The bench drives inputs on falling edges and keeps its own four-deep record of which cycles carried a pair and what that pair's decimal product is. At each falling edge it compares `out_valid` and `prod` with the oldest entry of that record. Directed single-pair runs also confirm that `out_valid` is still low three falling edges after the pair was driven and high on the fourth.

// File: rtl/bcdm_pkg.sv
`timescale 1ns/1ps
package bcdm_pkg;

  // One decimal digit plus carry-in. Returns {carry_out, digit}.
  function automatic logic [4:0] bcd_digit_add(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       ci);
    logic [4:0] s;
    s = {1'b0, x} + {1'b0, y} + {4'b0000, ci};
    if (s > 5'd9) s = s + 5'd6;
    return s;
  endfunction

  // Digit products that fall on decimal position p when both operands have n digits.
  function automatic int col_count(input int p, input int n);
    return (p < n) ? (p + 1) : (2 * n - 1 - p);
  endfunction

endpackage

// File: rtl/bcdm_col_stage.sv
`timescale 1ns/1ps
// Stage 1: digit-by-digit binary products, summed per decimal position.
module bcdm_col_stage #(
  parameter int N_DIG = 4,
  parameter int CW    = 9
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [4*N_DIG-1:0]           opa,
  input  logic [4*N_DIG-1:0]           opb,
  output logic                         col_valid,
  output logic [(2*N_DIG-1)*CW-1:0]    col_q
);
  import bcdm_pkg::*;

  localparam int NCOL = 2 * N_DIG - 1;

  logic [7:0]    dprod [N_DIG][N_DIG];
  logic [CW-1:0] col_d [NCOL];

  // 1x1-digit multipliers: plain 4x4 binary, at most 81.
  for (genvar gi = 0; gi < N_DIG; gi++) begin : g_row
    for (genvar gj = 0; gj < N_DIG; gj++) begin : g_col
      assign dprod[gi][gj] = {4'b0000, opa[4*gi +: 4]} * {4'b0000, opb[4*gj +: 4]};
    end
  end

  // Binary reduction of each column.
  always_comb begin
    for (int p = 0; p < NCOL; p++) begin
      col_d[p] = '0;
      for (int i = 0; i < N_DIG; i++) begin
        for (int j = 0; j < N_DIG; j++) begin
          if (i + j == p) col_d[p] = col_d[p] + CW'(dprod[i][j]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) col_valid <= 1'b0;
    else     col_valid <= in_valid;
    for (int p = 0; p < NCOL; p++) col_q[p*CW +: CW] <= col_d[p];
  end

  // R9: column totals stay within 81 times their operand count.
  for (genvar gp = 0; gp < NCOL; gp++) begin : g_chk
    p_col_bound_r9: assert property (@(posedge clk) disable iff (rst)
      col_valid |-> (int'(col_q[gp*CW +: CW]) <= 81 * col_count(gp, N_DIG)));
  end

endmodule

// File: rtl/bcdm_bin2dec.sv
`timescale 1ns/1ps
// Combinational shift-and-add-3 conversion of a column total to decimal.
module bcdm_bin2dec #(
  parameter int W = 9,
  parameter int D = 3
) (
  input  logic [W-1:0]   bin,
  output logic [4*D-1:0] dec
);
  logic [4*D-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = W - 1; k >= 0; k--) begin
      for (int q = 0; q < D; q++) begin
        if (acc[4*q +: 4] >= 4'd5) acc[4*q +: 4] = acc[4*q +: 4] + 4'd3;
      end
      acc = {acc[4*D-2:0], bin[k]};
    end
    dec = acc;
  end

endmodule

// File: rtl/bcdm_bcd_ripple.sv
`timescale 1ns/1ps
// Ripple-carry decimal adder, one digit cell per position.
module bcdm_bcd_ripple #(
  parameter int ND = 8
) (
  input  logic [4*ND-1:0] x,
  input  logic [4*ND-1:0] y,
  input  logic            cin,
  output logic [4*ND-1:0] sum,
  output logic            cout
);
  import bcdm_pkg::*;

  logic [ND:0] cy;
  assign cy[0] = cin;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [4:0] r;
    assign r              = bcd_digit_add(x[4*g +: 4], y[4*g +: 4], cy[g]);
    assign sum[4*g +: 4]  = r[3:0];
    assign cy[g+1]        = r[4];
  end

  assign cout = cy[ND];

endmodule

// File: rtl/bcdm_mul4.sv
`timescale 1ns/1ps
module bcdm_mul4 #(
  parameter int N_DIG = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [4*N_DIG-1:0]   opa,
  input  logic [4*N_DIG-1:0]   opb,
  output logic                 out_valid,
  output logic [8*N_DIG-1:0]   prod
);
  import bcdm_pkg::*;

  localparam int NCOL = 2 * N_DIG - 1;          // decimal positions of digit products
  localparam int PD   = 2 * N_DIG;              // product digits
  localparam int PW   = 4 * PD;                 // product bits
  localparam int CW   = $clog2(81 * N_DIG + 1); // column total width
  localparam int CD   = 3;                      // column decimal digits (<= 12 products)

  function automatic logic all_bcd(input logic [PW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int q = 0; q < PD; q++) if (v[4*q +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // ---------------- stage 1: multiply and column reduce ----------------
  logic                 v1;
  logic [NCOL*CW-1:0]   col_q;

  bcdm_col_stage #(.N_DIG(N_DIG), .CW(CW)) i_cols (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .opa      (opa),
    .opb      (opb),
    .col_valid(v1),
    .col_q    (col_q)
  );

  // ---------------- stage 2: column conversion, operand merge ----------------
  logic [4*CD-1:0] dec_col [NCOL];

  for (genvar gp = 0; gp < NCOL; gp++) begin : g_conv
    bcdm_bin2dec #(.W(CW), .D(CD)) i_conv (
      .bin (col_q[gp*CW +: CW]),
      .dec (dec_col[gp])
    );
  end

  logic [PW-1:0] ev_d, od_d, cy_d;
  logic [PW-1:0] ev_q, od_q, cy_q;
  logic          v2;

  // Even-based columns -> one operand, odd-based -> another,
  // and the hundreds digits of both sets land on distinct positions -> third.
  always_comb begin
    ev_d = '0;
    od_d = '0;
    cy_d = '0;
    for (int p = 0; p < NCOL; p++) begin
      if (p % 2 == 0) ev_d[4*p +: 8] = dec_col[p][7:0];
      else            od_d[4*p +: 8] = dec_col[p][7:0];
      if (p + 2 < PD) cy_d[4*(p+2) +: 4] = dec_col[p][11:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    ev_q <= ev_d;
    od_q <= od_d;
    cy_q <= cy_d;
  end

  // ---------------- stage 3: first decimal addition ----------------
  logic [PW-1:0] s3_d, s3_q, cy3_q;
  logic          c3;
  logic          v3;

  bcdm_bcd_ripple #(.ND(PD)) i_add1 (
    .x    (ev_q),
    .y    (od_q),
    .cin  (1'b0),
    .sum  (s3_d),
    .cout (c3)
  );

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= v2;
    s3_q  <= s3_d;
    cy3_q <= cy_q;
  end

  // ---------------- stage 4: second decimal addition ----------------
  logic [PW-1:0] s4_d;
  logic          c4;

  bcdm_bcd_ripple #(.ND(PD)) i_add2 (
    .x    (s3_q),
    .y    (cy3_q),
    .cin  (1'b0),
    .sum  (s4_d),
    .cout (c4)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v3;
    prod <= s4_d;
  end

  // ---------------- assertions ----------------
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4));

  p_rst_clear_r4: assert property (@(posedge clk)
    rst |=> !out_valid);

  p_mid_bcd_r5: assert property (@(posedge clk) disable iff (rst)
    v2 |-> (all_bcd(ev_q) && all_bcd(od_q) && all_bcd(cy_q)));

  p_out_bcd_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> all_bcd(prod));

  p_add1_nocarry_r8: assert property (@(posedge clk) disable iff (rst)
    v2 |-> !c3);

  p_add2_nocarry_r8: assert property (@(posedge clk) disable iff (rst)
    v3 |-> !c4);

  p_top_col_r9: assert property (@(posedge clk) disable iff (rst)
    v1 |-> (dec_col[NCOL-1][11:8] == 4'd0));

endmodule

// File: tb/test_bcdm_mul4.sv
`timescale 1ns/1ps
module test_bcdm_mul4;

  localparam int N  = 4;
  localparam int PW = 8 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [4*N-1:0] opa = '0, opb = '0;
  logic          out_valid;
  logic [PW-1:0] prod;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  bcdm_mul4 #(.N_DIG(N)) i_bcdm_mul4 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opa(opa), .opb(opb), .out_valid(out_valid), .prod(prod)
  );

  function automatic int from_bcd(input logic [63:0] v, input int nd);
    int r = 0;
    for (int q = nd - 1; q >= 0; q--) r = r * 10 + int'(v[4*q +: 4]);
    return r;
  endfunction

  function automatic logic [PW-1:0] to_bcd(input int v);
    logic [PW-1:0] r = '0;
    int t = v;
    for (int q = 0; q < 2 * N; q++) begin
      r[4*q +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [4*N-1:0] rand_op();
    logic [4*N-1:0] r;
    for (int q = 0; q < N; q++) r[4*q +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  function automatic bit digits_ok(input logic [PW-1:0] v);
    for (int q = 0; q < 2 * N; q++) if (v[4*q +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench latency record: expected validity and product, four deep.
  bit            m_v [4] = '{default: 1'b0};
  logic [PW-1:0] m_p [4];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) m_v[k] <= 1'b0;
    end else begin
      m_v[0] <= in_valid;
      m_p[0] <= to_bcd(from_bcd(64'(opa), N) * from_bcd(64'(opb), N));
      for (int k = 1; k < 4; k++) begin
        m_v[k] <= m_v[k-1];
        m_p[k] <= m_p[k-1];
      end
    end
  end

  // Compare outputs against the record at every falling edge.
  always @(negedge clk) begin
    if (model_on && !done) begin
      check(out_valid == m_v[3], "R3", "out_valid vs 4-cycle delayed in_valid",
            longint'(out_valid), longint'(m_v[3]));
      if (m_v[3] && out_valid) begin
        check(prod == m_p[3], "R1", "product", longint'(prod), longint'(m_p[3]));
        check(digits_ok(prod), "R5", "product digits legal", longint'(prod), longint'(m_p[3]));
      end
    end
  end

  // One pair in isolation: not due after three falling edges, due on the fourth.
  task automatic run_one(input logic [4*N-1:0] a, input logic [4*N-1:0] b,
                         input string tag);
    logic [PW-1:0] e;
    e = to_bcd(from_bcd(64'(a), N) * from_bcd(64'(b), N));
    @(negedge clk);
    opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R2", "result not early", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2", "result due after fourth edge", longint'(out_valid), 1);
    check(prod == e, tag, "directed product", longint'(prod), longint'(e));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R4: reset held with in_valid high keeps out_valid low.
    in_valid = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R4", "out_valid during reset", longint'(out_valid), 0);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    model_on = 1'b1;

    run_one(16'h9999, 16'h9999, "R6");
    run_one(16'h0000, 16'h1234, "R7");
    run_one(16'h5678, 16'h0000, "R7");
    run_one(16'h0000, 16'h0000, "R7");
    run_one(16'h0001, 16'h0001, "R1");
    run_one(16'h9999, 16'h0001, "R1");
    run_one(16'h9999, 16'h9990, "R8");
    run_one(16'h9009, 16'h9999, "R9");

    // R3: back-to-back stream at full rate, then sparse random stream.
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      opa = (n % 17 == 0) ? 16'h9999 : rand_op();
      opb = (n % 23 == 0) ? 16'h0000 : rand_op();
      in_valid = 1'b1;
    end
    for (int n = 0; n < 800; n++) begin
      @(negedge clk);
      opa = rand_op();
      opb = rand_op();
      in_valid = 1'($urandom % 2);
    end

    // R4: reset in the middle of a full pipeline flushes it.
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) begin
      check(out_valid == 1'b0, "R4", "flushed after mid-stream reset", longint'(out_valid), 0);
      @(negedge clk);
    end
    run_one(16'h4321, 16'h8765, "R1");

    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule